// File: doc/BRIEF.md
# CAN Receive Identifier Matcher

This block decides which receive buffer takes an incoming CAN frame. It looks at sixteen buffer descriptors, each holding a 4-bit state code, a 29-bit programmed identifier and an extended-format flag. It compares each programmed identifier with the received frame identifier through one shared acceptance mask. Because the mask can ignore some bits, a single buffer can accept a whole range of identifiers. Several buffers may hold the same identifier and so act as a reception queue. An empty buffer is served before a full one, and the lower index wins inside each class.

A run begins with a one-cycle start strobe, which also captures the frame identifier and its format flag. The matcher then looks at one buffer per clock, from index 0 up to 15. A processor write to a buffer's control/status word is reported through a write tag (a valid bit and a buffer index). Any buffer tagged between the start cycle and the last scan cycle is left out of that run. When the scan ends, a one-cycle done pulse appears. With it come a match-valid flag and the buffer index, and both hold their values until the next run ends.

Top module: `canRxMatcher`

## Requirements
- R1: During and after reset, before any run completes, done, matchValid and matchIdx are all 0.
- R2: For an extended frame (frameIde=1), a buffer's identifier matches when every bit position whose acceptMask bit is 1 is equal in frameId and the buffer identifier. Positions whose mask bit is 0 are ignored. The buffer's format flag must equal frameIde.
- R3: For a standard frame (frameIde=0), only bits 28..18 of frameId, of the buffer identifier and of acceptMask take part in the comparison. Bits 17..0 have no effect.
- R4: Only a buffer coded 4'b0100 (empty) or 4'b0010 (full) can match. Code 4'b0000 (idle) never matches, and neither does any other code, including all codes with bit 3 set.
- R5: Among the matching buffers, the lowest-index empty buffer is chosen. The lowest-index full buffer is chosen only when no empty buffer matches. Buffers sharing an identifier therefore fill in index order.
- R6: A write tag (cpuWrValid=1, cpuWrIdx=n) presented in the start cycle or in any scan cycle keeps buffer n out of that run's result. A write tag presented while no run is active has no effect.
- R7: If start is sampled at clock edge E, done is 1 for exactly one cycle, following edge E+16. At that point matchValid and matchIdx give the result. When nothing matched, matchValid=0 and matchIdx=0.
- R8: The frame identifier and format flag are captured at the start edge. A start strobe during a run is ignored, and so are later changes to frameId or frameIde during that run.
- R9: matchValid and matchIdx keep their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bufCode | input | 64 | State code per buffer, buffer n at bits [4n+3:4n] |
| bufId | input | 464 | Programmed identifier per buffer, buffer n at bits [29n+28:29n] |
| bufIde | input | 16 | Extended-format flag per buffer |
| acceptMask | input | 29 | Shared acceptance mask, 1 = bit must compare equal |
| frameId | input | 29 | Received identifier, standard IDs left-aligned in bits 28..18 |
| frameIde | input | 1 | Received frame is extended format |
| start | input | 1 | Begin a matching run |
| cpuWrValid | input | 1 | Processor is writing a buffer's control/status word |
| cpuWrIdx | input | 4 | Index of the buffer being written |
| done | output | 1 | One-cycle pulse at the end of a run |
| matchValid | output | 1 | A buffer was selected |
| matchIdx | output | 4 | Selected buffer index |

## Verification
Every run's result is due 16 clock edges after the edge that samples start. The bench drives start on a falling edge and counts falling edges from there. It checks that done is still low one cycle before the result is due, that done, matchValid and matchIdx are correct at the falling edge after edge sixteen, and that done is low again one cycle later. Write tags and ignored start strobes are placed on chosen falling edges inside the scan window. Hold behaviour is checked several cycles after a done pulse, once the frame inputs have changed.

// File: rtl/canMatchPkg.sv
package canMatchPkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_RX_IDLE  = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_RX_FULL  = 4'b0010;
  localparam logic [CODE_W-1:0] CODE_RX_EMPTY = 4'b0100;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRun;     // start accepted: capture frame, clear run state
    logic recordHit;    // a scan cycle: evaluate the addressed buffer
    logic finish;       // last scan cycle: load result registers
  } ctrlStrb_t;

endpackage

// File: rtl/canMatchCtrl.sv
module canMatchCtrl
  import canMatchPkg::*;
#(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output ctrlStrb_t        strb,
  output logic [IDX_W-1:0] scanIdx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;

  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SCAN;
            cnt   <= '0;
          end
        end
        ST_SCAN: begin
          if (cnt == LAST_IDX) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clearRun  = (state == ST_IDLE) && start;
    strb.recordHit = (state == ST_SCAN);
    strb.finish    = (state == ST_SCAN) && (cnt == LAST_IDX);
  end

  assign scanIdx = cnt;

  always_ff @(posedge clk) begin
    if (rst) doneQ <= 1'b0;
    else     doneQ <= strb.finish;
  end

  assign done = doneQ;

  // R7: done never lasts longer than one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R8: a started run keeps scanning until its last buffer, start or not
  p_run_uninterrupted_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && cnt != LAST_IDX) |=> (state == ST_SCAN && cnt == $past(cnt) + 1'b1));

  // R7: the scan begins with buffer 0 after an accepted start
  p_scan_from_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_SCAN && cnt == '0));

endmodule

// File: rtl/canMatchDatapath.sv
module canMatchDatapath
  import canMatchPkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BUF*CODE_W-1:0] bufCode,
  input  logic [NUM_BUF*ID_W-1:0]   bufId,
  input  logic [NUM_BUF-1:0]        bufIde,
  input  logic [ID_W-1:0]           acceptMask,
  input  logic [ID_W-1:0]           frameId,
  input  logic                      frameIde,
  input  logic                      cpuWrValid,
  input  logic [IDX_W-1:0]          cpuWrIdx,
  input  ctrlStrb_t                 strb,
  input  logic [IDX_W-1:0]          scanIdx,
  output logic                      matchValid,
  output logic [IDX_W-1:0]          matchIdx
);

  // Descriptor unpacking
  logic [CODE_W-1:0] codeArr [NUM_BUF];
  logic [ID_W-1:0]   idArr   [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_unpack
    assign codeArr[g] = bufCode[g*CODE_W +: CODE_W];
    assign idArr[g]   = bufId[g*ID_W +: ID_W];
  end

  // Captured frame
  logic [ID_W-1:0] frameIdQ;
  logic            frameIdeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameIdQ  <= '0;
      frameIdeQ <= 1'b0;
    end else if (strb.clearRun) begin
      frameIdQ  <= frameId;
      frameIdeQ <= frameIde;
    end
  end

  // Compare of the buffer addressed this cycle
  logic [CODE_W-1:0] curCode;
  logic [ID_W-1:0]   curId;
  logic              curIde;
  logic [ID_W-1:0]   diffBits;
  logic              idEqual;
  logic              fmtEqual;
  logic              hitEmpty;
  logic              hitFull;

  always_comb begin
    curCode  = codeArr[scanIdx];
    curId    = idArr[scanIdx];
    curIde   = bufIde[scanIdx];
    diffBits = (frameIdQ ^ curId) & acceptMask;
    if (frameIdeQ) idEqual = (diffBits == '0);
    else           idEqual = (diffBits[ID_W-1 -: STD_W] == '0);
    fmtEqual = (curIde == frameIdeQ);
    hitEmpty = idEqual && fmtEqual && (curCode == CODE_RX_EMPTY);
    hitFull  = idEqual && fmtEqual && (curCode == CODE_RX_FULL);
  end

  // Run state: hit vectors and exclusion set
  logic [NUM_BUF-1:0] emptyQ, fullQ, exclQ;
  logic [NUM_BUF-1:0] emptyNext, fullNext, exclNext;
  logic [NUM_BUF-1:0] wrVec;
  logic               runLive;

  assign runLive = strb.clearRun || strb.recordHit;

  always_comb begin
    wrVec = '0;
    if (cpuWrValid && runLive) wrVec[cpuWrIdx] = 1'b1;
  end

  always_comb begin
    emptyNext = emptyQ;
    fullNext  = fullQ;
    exclNext  = exclQ | wrVec;
    if (strb.clearRun) begin
      emptyNext = '0;
      fullNext  = '0;
      exclNext  = wrVec;
    end else if (strb.recordHit) begin
      emptyNext[scanIdx] = hitEmpty;
      fullNext[scanIdx]  = hitFull;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      emptyQ <= '0;
      fullQ  <= '0;
      exclQ  <= '0;
    end else begin
      emptyQ <= emptyNext;
      fullQ  <= fullNext;
      exclQ  <= exclNext;
    end
  end

  // Lowest-index priority pick
  function automatic logic [IDX_W:0] pickLowest(input logic [NUM_BUF-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [NUM_BUF-1:0] emptyOk, fullOk;
  logic [IDX_W:0]     pickEmpty, pickFull;
  logic               resValid;
  logic [IDX_W-1:0]   resIdx;

  always_comb begin
    emptyOk   = emptyNext & ~exclNext;
    fullOk    = fullNext & ~exclNext;
    pickEmpty = pickLowest(emptyOk);
    pickFull  = pickLowest(fullOk);
    if (pickEmpty[IDX_W]) begin
      resValid = 1'b1;
      resIdx   = pickEmpty[IDX_W-1:0];
    end else if (pickFull[IDX_W]) begin
      resValid = 1'b1;
      resIdx   = pickFull[IDX_W-1:0];
    end else begin
      resValid = 1'b0;
      resIdx   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matchValid <= 1'b0;
      matchIdx   <= '0;
    end else if (strb.finish) begin
      matchValid <= resValid;
      matchIdx   <= resIdx;
    end
  end

  // R6: a buffer tagged during the run is never the reported winner
  p_excluded_loses_r6: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> !(matchValid && exclQ[matchIdx]));

  // R9: result registers move only at the end of a run
  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strb.finish |=> ($stable(matchValid) && $stable(matchIdx)));

  // R7: no match reports index 0
  p_nomatch_idx_r7: assert property (@(posedge clk) disable iff (rst)
    !matchValid |-> (matchIdx == '0));

  // R5: a full buffer wins only when no non-excluded empty buffer was hit
  p_empty_first_r5: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> !(matchValid && fullQ[matchIdx] && !emptyQ[matchIdx]
                      && ((emptyQ & ~exclQ) != '0)));

endmodule

// File: rtl/canRxMatcher.sv
module canRxMatcher
  import canMatchPkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BUF*CODE_W-1:0] bufCode,
  input  logic [NUM_BUF*ID_W-1:0]   bufId,
  input  logic [NUM_BUF-1:0]        bufIde,
  input  logic [ID_W-1:0]           acceptMask,
  input  logic [ID_W-1:0]           frameId,
  input  logic                      frameIde,
  input  logic                      start,
  input  logic                      cpuWrValid,
  input  logic [IDX_W-1:0]          cpuWrIdx,
  output logic                      done,
  output logic                      matchValid,
  output logic [IDX_W-1:0]          matchIdx
);

  ctrlStrb_t        strb;
  logic [IDX_W-1:0] scanIdx;

  canMatchCtrl #(.NUM_BUF(NUM_BUF)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strb    (strb),
    .scanIdx (scanIdx),
    .done    (done)
  );

  canMatchDatapath #(
    .NUM_BUF (NUM_BUF),
    .ID_W    (ID_W),
    .STD_W   (STD_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .bufCode    (bufCode),
    .bufId      (bufId),
    .bufIde     (bufIde),
    .acceptMask (acceptMask),
    .frameId    (frameId),
    .frameIde   (frameIde),
    .cpuWrValid (cpuWrValid),
    .cpuWrIdx   (cpuWrIdx),
    .strb       (strb),
    .scanIdx    (scanIdx),
    .matchValid (matchValid),
    .matchIdx   (matchIdx)
  );

  // R1: nothing is reported while reset is applied on the previous edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && !matchValid && matchIdx == '0));

endmodule

// File: tb/tb_canRxMatcher.sv
module tb_canRxMatcher;

  localparam int NB = 16;
  localparam int IW = 29;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NB*4-1:0] bufCode = '0;
  logic [NB*IW-1:0] bufId = '0;
  logic [NB-1:0]   bufIde = '0;
  logic [IW-1:0]   acceptMask = '0;
  logic [IW-1:0]   frameId = '0;
  logic            frameIde = 1'b0;
  logic            start = 1'b0;
  logic            cpuWrValid = 1'b0;
  logic [3:0]      cpuWrIdx = '0;
  logic            done;
  logic            matchValid;
  logic [3:0]      matchIdx;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  canRxMatcher dut (
    .clk(clk), .rst(rst), .bufCode(bufCode), .bufId(bufId), .bufIde(bufIde),
    .acceptMask(acceptMask), .frameId(frameId), .frameIde(frameIde),
    .start(start), .cpuWrValid(cpuWrValid), .cpuWrIdx(cpuWrIdx),
    .done(done), .matchValid(matchValid), .matchIdx(matchIdx)
  );

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        expV;
    logic [3:0]  expI;
  } vec_t;

  localparam logic [28:0] STD123 = 29'(11'h123) << 18;

  localparam vec_t VECS [9] = '{
    '{29'h100,             1'b1, 1'b1, 4'd2},  // R5 empty over lower full
    '{29'h10F,             1'b1, 1'b1, 4'd2},  // R2 masked low bits
    '{29'h110,             1'b1, 1'b0, 4'd0},  // R2 compared bit differs
    '{29'h200,             1'b1, 1'b0, 4'd0},  // R4 transmit code
    '{STD123 | 29'h00055,  1'b0, 1'b1, 4'd5},  // R3 low bits ignored
    '{STD123,              1'b1, 1'b0, 4'd0},  // R2 format mismatch
    '{29'h300,             1'b1, 1'b1, 4'd6},  // R5 full only
    '{29'h400,             1'b0, 1'b0, 4'd0},  // R4 idle buffers never match
    '{29'h401,             1'b1, 1'b1, 4'd7}   // R2 masked range
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setBuf(input int n, input logic [3:0] code, input logic [28:0] id, input logic ide);
    bufCode[n*4 +: 4]  = code;
    bufId[n*IW +: IW]  = id;
    bufIde[n]          = ide;
  endtask

  // Leaves the bench at the falling edge after the start edge
  task automatic startRun(input logic [28:0] id, input logic ide);
    @(negedge clk);
    frameId  = id;
    frameIde = ide;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkResult(input string tag, input logic v, input logic [3:0] idx);
    chk(done == 1'b1, {tag, " done"}, done, 1);
    chk(matchValid == v, {tag, " valid"}, matchValid, v);
    chk(matchIdx == idx, {tag, " idx"}, matchIdx, idx);
  endtask

  initial begin : watchdog
    #(20 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NB; i++) setBuf(i, 4'b0000, '0, 1'b0);
    setBuf(0, 4'b0000, 29'h100, 1'b1);
    setBuf(1, 4'b0010, 29'h100, 1'b1);
    setBuf(2, 4'b0100, 29'h100, 1'b1);
    setBuf(3, 4'b0100, 29'h100, 1'b1);
    setBuf(4, 4'b1100, 29'h200, 1'b1);
    setBuf(5, 4'b0100, STD123 | 29'h3ABCD, 1'b0);
    setBuf(6, 4'b0010, 29'h300, 1'b1);
    setBuf(7, 4'b0100, 29'h400, 1'b1);
    acceptMask = 29'h1FFF_FFF0;

    waitNeg(3);
    // R1 reset state
    chk(done == 1'b0 && matchValid == 1'b0 && matchIdx == 4'd0, "R1 reset outputs",
        {done, matchValid, matchIdx}, 0);
    rst = 1'b0;
    waitNeg(2);
    chk(done == 1'b0 && matchValid == 1'b0, "R1 idle after reset", {done, matchValid}, 0);

    // Vector table
    for (int v = 0; v < 9; v++) begin
      startRun(VECS[v].id, VECS[v].ide);
      waitNeg(15);
      chk(done == 1'b0, $sformatf("R7 vec%0d done early", v), done, 0);
      waitNeg(1);
      checkResult($sformatf("R2-table vec%0d", v), VECS[v].expV, VECS[v].expI);
      waitNeg(1);
      chk(done == 1'b0, $sformatf("R7 vec%0d done one cycle", v), done, 0);
    end

    // R6 exclusion of buffer 2 -> queue partner 3
    startRun(29'h100, 1'b1);
    waitNeg(2);
    cpuWrValid = 1'b1; cpuWrIdx = 4'd2;
    @(negedge clk);
    cpuWrValid = 1'b0;
    waitNeg(13);
    checkResult("R6 excl buf2", 1'b1, 4'd3);

    // R6 exclude 2 (start cycle) and 3 -> full buffer 1
    @(negedge clk);
    frameId = 29'h100; frameIde = 1'b1; start = 1'b1;
    cpuWrValid = 1'b1; cpuWrIdx = 4'd2;
    @(negedge clk);
    start = 1'b0; cpuWrIdx = 4'd3;
    @(negedge clk);
    cpuWrValid = 1'b0;
    waitNeg(15);
    checkResult("R6 excl buf2 buf3", 1'b1, 4'd1);

    // R6 tag while idle has no effect
    waitNeg(2);
    cpuWrValid = 1'b1; cpuWrIdx = 4'd2;
    @(negedge clk);
    cpuWrValid = 1'b0;
    startRun(29'h100, 1'b1);
    waitNeg(16);
    checkResult("R6 idle tag ignored", 1'b1, 4'd2);

    // R8 restart and frame change mid-run ignored
    startRun(29'h100, 1'b1);
    waitNeg(4);
    frameId = 29'h300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitNeg(10);
    chk(done == 1'b0, "R8 no early done", done, 0);
    @(negedge clk);
    checkResult("R8 mid-run start", 1'b1, 4'd2);

    // R9 hold after done
    frameId = 29'h110;
    waitNeg(4);
    chk(done == 1'b0, "R9 done low", done, 0);
    chk(matchValid == 1'b1 && matchIdx == 4'd2, "R9 result held", {matchValid, matchIdx}, 5'h12);

    // R2 full mask: low bits now compared
    acceptMask = 29'h1FFF_FFFF;
    startRun(29'h10F, 1'b1);
    waitNeg(16);
    checkResult("R2 full mask", 1'b0, 4'd0);

    // R4 idle buffer 0 turned empty now wins the queue
    setBuf(0, 4'b0100, 29'h100, 1'b1);
    startRun(29'h100, 1'b1);
    waitNeg(16);
    checkResult("R4 R5 buf0 empty", 1'b1, 4'd0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule